// File: doc/BRIEF.md
# LCD Row Scan Timing Generator

This block produces the row-side timing for a dot-matrix liquid crystal panel. It runs from one system clock and sends three signals to the row driver. The first is a single-cycle frame start pulse that marks the top row. The second is a single-cycle line latch pulse that moves that start marker down one row per line period. The third is a polarity level that the driver uses to alternate the sign of the drive voltage, so that the panel sees no net DC bias.

All periods are whole numbers of clock cycles and are set by parameters. With a 0.625 MHz clock, a line period of 78 cycles comes close to 125 µs. Sixty-four lines then make a frame of about 8 ms. With the polarity flipping once per frame, one full polarity cycle spans two frames, about 16 ms. The block has no inputs besides clock and reset. After a synchronous reset it restarts from row zero with the polarity low.

Top module: `lcd_rowscan_timing`

## Requirements
- R1: While reset is sampled high, the next cycle shows `line_latch`, `frame_start` and `ac_polarity` all at 0.
- R2: `line_latch` is high for exactly one cycle in every LINE_CYCLES cycles. Its first assertion after reset is in the LINE_CYCLES-th cycle after the last reset edge, counting that edge's following cycle as the first.
- R3: `frame_start` is high for one cycle only, and only in a cycle where `line_latch` is also high.
- R4: Between two consecutive `frame_start` pulses there are exactly ROWS `line_latch` pulses, counting the one that coincides with the earlier start.
- R5: The first `line_latch` pulse after reset comes together with a `frame_start` pulse.
- R6: `ac_polarity` changes only in the cycle right after a `frame_start` pulse. The default variant (POL_FRAMES = 1) changes it after every start pulse.
- R7: Each level of `ac_polarity` lasts exactly POL_FRAMES × ROWS × LINE_CYCLES cycles. With the defaults this gives two frames per full polarity period.
- R8: A reset in the middle of a frame, including one that lands on a start pulse, discards the row position and the polarity. Timing then resumes exactly as it does after the first reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | output | 1 | One-cycle pulse on the latch of the top row |
| line_latch | output | 1 | One-cycle pulse at the last cycle of each line period |
| ac_polarity | output | 1 | Drive polarity level, flips on frame boundaries |

## Verification
The embedded properties assume that `rst` has a known value at the first rising edge and is high there, and that it changes only between edges. The bench therefore starts with reset high from time zero. It moves `rst` one time unit after a rising edge and holds each reset for a random number of edges. The random pieces are the reset instants and the run lengths between resets, drawn from a fixed seed. One directed reset is placed on the edge that closes a start pulse. A second instance with a short line, four rows and a two-frame polarity variant covers the counter-based polarity path.

// File: rtl/lcd_rowscan_pkg.sv
package lcd_rowscan_pkg;

   // width of a counter that must hold values 0 .. n-1 (at least one bit)
   function automatic int unsigned cnt_width(input int unsigned n);
      int unsigned w;
      w = (n <= 2) ? 1 : $clog2(n);
      return w;
   endfunction

   typedef struct packed {
      logic start;
      logic latch;
   } scan_pulse_t;

endpackage

// File: rtl/line_timer.sv
module line_timer
   import lcd_rowscan_pkg::*;
#(
   parameter int unsigned LINE_CYCLES = 78
) (
   input  logic clk,
   input  logic rst,
   output logic line_tick
);

   localparam int unsigned CW = cnt_width(LINE_CYCLES);
   localparam logic [CW-1:0] CNT_LAST = CW'(LINE_CYCLES - 1);

   if (LINE_CYCLES < 2) begin : g_bad_line
      $error("line_timer: LINE_CYCLES must be at least 2");
   end

   logic [CW-1:0] cyc_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cyc_q <= '0;
      end else if (cyc_q == CNT_LAST) begin
         cyc_q <= '0;
      end else begin
         cyc_q <= cyc_q + 1'b1;
      end
   end

   assign line_tick = (cyc_q == CNT_LAST);

   // R2: a tick never lasts two cycles
   a_r2_tick_single: assert property (@(posedge clk) disable iff (rst)
      line_tick |=> !line_tick)
      else $error("R2: line tick held for two cycles");

   // R2: counter stays within the line period
   a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
      cyc_q <= CNT_LAST)
      else $error("R2: line counter out of range");

   // R1: reset restarts the line
   a_r1_line_reset: assert property (@(posedge clk)
      rst |=> (cyc_q == '0))
      else $error("R1: line counter not cleared by reset");

endmodule

// File: rtl/row_sequencer.sv
module row_sequencer
   import lcd_rowscan_pkg::*;
#(
   parameter int unsigned ROWS = 64
) (
   input  logic clk,
   input  logic rst,
   input  logic line_tick,
   output logic frame_start
);

   localparam int unsigned RW = cnt_width(ROWS);
   localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

   if (ROWS < 2) begin : g_bad_rows
      $error("row_sequencer: ROWS must be at least 2");
   end

   logic [RW-1:0] row_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         row_q <= '0;
      end else if (line_tick) begin
         row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
      end
   end

   assign frame_start = line_tick && (row_q == '0);

   // R3: a start pulse only rides on a latch pulse
   a_r3_start_on_latch: assert property (@(posedge clk) disable iff (rst)
      frame_start |-> line_tick)
      else $error("R3: start without latch");

   // R4: row advances by one on every latch below the last row
   a_r4_row_step: assert property (@(posedge clk) disable iff (rst)
      (line_tick && row_q != ROW_LAST) |=> (row_q == $past(row_q) + 1'b1))
      else $error("R4: row did not advance");

   // R4: row wraps after the last row
   a_r4_row_wrap: assert property (@(posedge clk) disable iff (rst)
      (line_tick && row_q == ROW_LAST) |=> (row_q == '0))
      else $error("R4: row did not wrap");

   // R4: row holds between latches
   a_r4_row_hold: assert property (@(posedge clk) disable iff (rst)
      !line_tick |=> $stable(row_q))
      else $error("R4: row moved without latch");

   // R5 / R8: reset returns to the top row
   a_r5_row_reset: assert property (@(posedge clk)
      rst |=> (row_q == '0))
      else $error("R5: row not cleared by reset");

endmodule

// File: rtl/polarity_gen.sv
module polarity_gen
   import lcd_rowscan_pkg::*;
#(
   parameter int unsigned POL_FRAMES = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic frame_start,
   output logic polarity
);

   if (POL_FRAMES < 1) begin : g_bad_pol
      $error("polarity_gen: POL_FRAMES must be at least 1");
   end

   logic pol_q;

   if (POL_FRAMES == 1) begin : g_every_frame
      always_ff @(posedge clk) begin
         if (rst) begin
            pol_q <= 1'b0;
         end else if (frame_start) begin
            pol_q <= ~pol_q;
         end
      end
   end else begin : g_multi_frame
      localparam int unsigned FW = cnt_width(POL_FRAMES);
      localparam logic [FW-1:0] FR_LAST = FW'(POL_FRAMES - 1);
      logic [FW-1:0] frm_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            frm_q <= '0;
            pol_q <= 1'b0;
         end else if (frame_start) begin
            if (frm_q == FR_LAST) begin
               frm_q <= '0;
               pol_q <= ~pol_q;
            end else begin
               frm_q <= frm_q + 1'b1;
            end
         end
      end

      // R7: no flip on a start pulse that is not the last of the group
      a_r7_group_hold: assert property (@(posedge clk) disable iff (rst)
         (frame_start && frm_q != FR_LAST) |=> $stable(pol_q))
         else $error("R7: polarity flipped inside a frame group");
   end

   assign polarity = pol_q;

   // R6: polarity is steady unless a start pulse just occurred
   a_r6_flip_on_frame: assert property (@(posedge clk) disable iff (rst)
      !frame_start |=> $stable(pol_q))
      else $error("R6: polarity changed away from a frame boundary");

   // R8: reset forces the low level
   a_r8_pol_reset: assert property (@(posedge clk)
      rst |=> !pol_q)
      else $error("R8: polarity not cleared by reset");

endmodule

// File: rtl/lcd_rowscan_timing.sv
module lcd_rowscan_timing
   import lcd_rowscan_pkg::*;
#(
   parameter int unsigned LINE_CYCLES = 78,
   parameter int unsigned ROWS        = 64,
   parameter int unsigned POL_FRAMES  = 1
) (
   input  logic clk,
   input  logic rst,
   output logic frame_start,
   output logic line_latch,
   output logic ac_polarity
);

   scan_pulse_t pulse;

   line_timer #(
      .LINE_CYCLES(LINE_CYCLES)
   ) u_line (
      .clk      (clk),
      .rst      (rst),
      .line_tick(pulse.latch)
   );

   row_sequencer #(
      .ROWS(ROWS)
   ) u_rows (
      .clk        (clk),
      .rst        (rst),
      .line_tick  (pulse.latch),
      .frame_start(pulse.start)
   );

   polarity_gen #(
      .POL_FRAMES(POL_FRAMES)
   ) u_pol (
      .clk        (clk),
      .rst        (rst),
      .frame_start(pulse.start),
      .polarity   (ac_polarity)
   );

   assign frame_start = pulse.start;
   assign line_latch  = pulse.latch;

   // R3: start pulse is one cycle wide at the ports
   a_r3_start_single: assert property (@(posedge clk) disable iff (rst)
      frame_start |=> !frame_start)
      else $error("R3: start pulse longer than one cycle");

endmodule

// File: tb/test_lcd_rowscan_timing.sv
module scan_monitor #(
   parameter int LC   = 78,
   parameter int ROWS = 64,
   parameter int PF   = 1
) (
   input logic clk,
   input logic rst,
   input logic start,
   input logic latch,
   input logic pol
);
   int n_checks = 0;
   int n_fail   = 0;

   // reference state, advanced per rising edge
   int m_cnt = 0, m_row = 0, m_frm = 0;
   bit m_pol = 0;
   bit r_prev = 1;       // reset sampled at the last edge
   bit ran = 0;          // any non-reset cycle seen
   bit first_pulse = 1;
   int since_lat = 0;
   int lat_cnt = 0;
   bit have_start = 0;
   int since_pol = 0;
   bit have_pol_edge = 0;
   bit prev_start = 0;
   bit prev_pol = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s (LC=%0d ROWS=%0d PF=%0d) at %0t: actual %0d expected %0d",
                  req, LC, ROWS, PF, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      bit m_lat, m_st;
      m_lat = (m_cnt == LC - 1);
      m_st  = m_lat && (m_row == 0);

      if (r_prev) begin
         // R1 / R8: outputs cleared after a reset edge
         chk(!latch && !start && !pol, ran ? "R8" : "R1",
             {29'd0, latch, start, pol}, 0);
         since_lat   = 1;
         first_pulse = 1;
         lat_cnt     = 0;
         have_start  = 0;
         since_pol   = 1;
         have_pol_edge = 0;
      end else begin
         ran = 1;
         since_lat++;
         since_pol++;
         // R6: polarity moves only right after a start pulse
         if (pol != prev_pol) begin
            chk(prev_start, "R6", int'(prev_start), 1);
            if (have_pol_edge)
               chk(since_pol == PF * ROWS * LC, "R7", since_pol, PF * ROWS * LC);
            have_pol_edge = 1;
            since_pol = 0;
         end
         if (start) begin
            chk(latch, "R3", int'(latch), 1);
            chk(!prev_start, "R3", int'(prev_start), 0);
         end
      end

      // cycle-by-cycle comparison with the reference
      chk(latch == m_lat, "R2", int'(latch), int'(m_lat));
      chk(start == m_st,  "R3", int'(start), int'(m_st));
      chk(pol == m_pol,   "R6", int'(pol),   int'(m_pol));

      if (latch) begin
         chk(since_lat == LC, "R2", since_lat, LC);
         since_lat = 0;
         if (first_pulse) begin
            chk(start, "R5", int'(start), 1);
            first_pulse = 0;
         end
         if (start) begin
            if (have_start) chk(lat_cnt == ROWS, "R4", lat_cnt, ROWS);
            have_start = 1;
            lat_cnt = 1;
         end else begin
            lat_cnt++;
         end
      end

      prev_start = start;
      prev_pol   = pol;

      // advance the reference over the coming edge
      if (rst) begin
         m_cnt = 0; m_row = 0; m_frm = 0; m_pol = 0;
      end else begin
         if (m_st) begin
            if (m_frm == PF - 1) begin m_frm = 0; m_pol = !m_pol; end
            else m_frm++;
         end
         if (m_lat) begin
            m_row = (m_row == ROWS - 1) ? 0 : m_row + 1;
            m_cnt = 0;
         end else begin
            m_cnt++;
         end
      end
      r_prev = rst;
   end
endmodule

module test_lcd_rowscan_timing;
   localparam int CLK_PERIOD = 10;
   localparam int FRAME_DEF  = 78 * 64;

   logic clk = 1'b0;
   logic rst = 1'b1;
   bit   done = 0;
   int   wd_fail = 0;

   logic fs, ll, pl;
   logic fs2, ll2, pl2;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lcd_rowscan_timing i_lcd_rowscan_timing (
      .clk(clk), .rst(rst),
      .frame_start(fs), .line_latch(ll), .ac_polarity(pl)
   );

   lcd_rowscan_timing #(.LINE_CYCLES(5), .ROWS(4), .POL_FRAMES(2)) i_lcd_rowscan_timing_alt (
      .clk(clk), .rst(rst),
      .frame_start(fs2), .line_latch(ll2), .ac_polarity(pl2)
   );

   scan_monitor #(.LC(78), .ROWS(64), .PF(1)) i_mon (
      .clk(clk), .rst(rst), .start(fs), .latch(ll), .pol(pl));
   scan_monitor #(.LC(5), .ROWS(4), .PF(2)) i_mon_alt (
      .clk(clk), .rst(rst), .start(fs2), .latch(ll2), .pol(pl2));

   task automatic run_cycles(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_reset(input int n);
      rst = 1'b1;
      run_cycles(n);
      rst = 1'b0;
   endtask

   task automatic report();
      int total, failed;
      total  = i_mon.n_checks + i_mon_alt.n_checks + 1;
      failed = i_mon.n_fail + i_mon_alt.n_fail + wd_fail;
      $display("  [TB] %0d tests run, %0d failed", total, failed);
   endtask

   initial begin
      void'($urandom(32'h1c0d_5a11));
      run_cycles(4);
      rst = 1'b0;
      // R2 R4 R5 R6: several undisturbed frames
      run_cycles(3 * FRAME_DEF + 100);
      // R8: random mid-frame resets of random length
      for (int i = 0; i < 8; i++) begin
         do_reset(1 + int'($urandom % 3));
         run_cycles(int'($urandom_range(6000, 50)));
      end
      // R8: reset edge lands exactly on the first start pulse
      do_reset(2);
      run_cycles(78 - 1);
      do_reset(1);
      // R7: long free run to measure whole polarity levels
      run_cycles(5 * FRAME_DEF);
      done = 1;
      report();
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         wd_fail = 1;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
         $finish;
      end
   end
endmodule